// File: doc/BRIEF.md
# Adaptive Test Interval Scheduler

This block decides when a self-test phase of a monitored logic unit begins and which test clock step the phase uses. It keeps a sliding record of the pass/fail outcome of the most recent test injections. Each time a phase starts, it turns the number of failures in that record into the length of the next wait. Under the linear policy the wait shrinks by a fixed amount per failure. Under the halving policy the wait is divided by two for every failure. A clean record therefore keeps the longest wait.

In opportunistic mode the start is tied to the unit's idle cycles. The second half of each wait is a window. The phase starts on the first idle cycle seen inside that window. If no idle cycle arrives, the phase is forced at the end of the wait. The test clock step is the requested base step. In late-life mode it is raised by one step for every fixed rise of the temperature code above a reference, saturating at the fastest step. The step is captured when the phase starts, so it holds for the whole phase.

Top module: `test_interval_sched`

## Requirements
- R1: While reset is asserted, `phase_start` and `freq_sel` are 0. The first strobe after reset comes INT+1 cycles after the release, where INT is the wait for zero failures under the policy applied at release.
- R2: The failure count covers only the last HIST_LEN results that arrive with `res_valid`=1. A fail is `res_fail`=1. Older results no longer count.
- R3: With `policy_sel`=0 (linear), consecutive strobes are LIN_BASE − k·LIN_STEP cycles apart. Here k is the failure count at the earlier strobe.
- R4: With `policy_sel`=1 (halving), consecutive strobes are EXP_BASE / 2^k cycles apart. Here k is the failure count at the earlier strobe.
- R5: `phase_start` is high for exactly one cycle. The policy and the failure count are sampled at a strobe, so a policy change affects only the wait that begins at the next strobe.
- R6: With `opp_en`=1, an idle cycle sampled j cycles after a strobe starts the phase (strobe gap j) only if j ≥ INT − ⌊INT/2⌋. Idle cycles sampled earlier have no effect.
- R7: With no idle cycle inside the window, or with `opp_en`=0, the strobe is forced exactly INT cycles after the previous one.
- R8: `freq_sel` changes only in the cycle in which `phase_start` is high. With `late_en`=0 it takes the value of `freq_base`, clamped to NUM_FREQ−1.
- R9: With `late_en`=1, `freq_sel` = min(`freq_base` + ⌊(`temp_code` − TEMP_REF)/TEMP_STEP⌋, NUM_FREQ−1) when `temp_code` > TEMP_REF. Otherwise it is `freq_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 1 | 0 linear shrink, 1 halving per failure |
| opp_en | input | 1 | Start phases on idle cycles inside the window |
| late_en | input | 1 | Raise the test clock step with temperature |
| idle | input | 1 | Monitored unit is idle this cycle |
| res_valid | input | 1 | A test result is presented |
| res_fail | input | 1 | The presented result is a failure |
| freq_base | input | $clog2(NUM_FREQ) | Requested test clock step, 0 is nominal |
| temp_code | input | TEMP_W | Temperature reading |
| phase_start | output | 1 | One-cycle strobe starting a test phase |
| freq_sel | output | $clog2(NUM_FREQ) | Test clock step for the current phase |

## Verification
The hardest case to reach is the exact edge of the opportunistic window. It needs an idle pulse one cycle before the window opens and another pulse on the first cycle inside it. Both are placed by counting cycles from the preceding strobe. A second difficulty is that a failure count only shapes the wait after the strobe that samples it. The bench therefore loads the history just after one strobe, lets the next strobe sample it, and measures the gap that follows. The halving policy at full failure count gives gaps shorter than a result burst, so each scenario starts from reset.

// File: rtl/tis_pkg.sv
package tis_pkg;

   typedef enum logic {
      POL_LINEAR  = 1'b0,
      POL_HALVING = 1'b1
   } policy_e;

endpackage

// File: rtl/tis_fail_window.sv
module tis_fail_window #(
   parameter int unsigned HIST_LEN = 8,
   localparam int unsigned CW = $clog2(HIST_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          res_valid,
   input  logic          res_fail,
   output logic [CW-1:0] fail_cnt
);

   logic [HIST_LEN-1:0] hist;

   for (genvar i = 0; i < HIST_LEN; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hist[0] <= 1'b0;
            else if (res_valid) hist[0] <= res_fail;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hist[i] <= 1'b0;
            else if (res_valid) hist[i] <= hist[i-1];
         end
      end
   end

   always_comb begin
      fail_cnt = '0;
      for (int k = 0; k < HIST_LEN; k++)
         fail_cnt = fail_cnt + CW'(hist[k]);
   end

   // R2
   fail_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fail && !hist[HIST_LEN-1]) |=> (fail_cnt == $past(fail_cnt) + 1'b1));

endmodule

// File: rtl/tis_interval_calc.sv
module tis_interval_calc
   import tis_pkg::*;
#(
   parameter int unsigned CNT_W    = 20,
   parameter int unsigned HIST_LEN = 8,
   parameter int unsigned LIN_BASE = 100000,
   parameter int unsigned LIN_STEP = 11250,
   parameter int unsigned EXP_BASE = 1000000,
   localparam int unsigned CW = $clog2(HIST_LEN + 1)
) (
   input  policy_e          pol,
   input  logic [CW-1:0]    fail_cnt,
   output logic [CNT_W-1:0] interval
);

   logic [31:0] lin_val;
   logic [31:0] exp_val;

   always_comb begin
      lin_val  = LIN_BASE - (32'(fail_cnt) * LIN_STEP);
      exp_val  = EXP_BASE >> fail_cnt;
      interval = (pol == POL_HALVING) ? CNT_W'(exp_val) : CNT_W'(lin_val);
   end

endmodule

// File: rtl/tis_freq_pick.sv
module tis_freq_pick #(
   parameter int unsigned NUM_FREQ  = 4,
   parameter int unsigned TEMP_W    = 8,
   parameter int unsigned TEMP_REF  = 40,
   parameter int unsigned TEMP_STEP = 5,
   localparam int unsigned FW = $clog2(NUM_FREQ)
) (
   input  logic              late_en,
   input  logic [FW-1:0]     freq_base,
   input  logic [TEMP_W-1:0] temp_code,
   output logic [FW-1:0]     next_sel
);

   localparam int unsigned TOP_STEP = NUM_FREQ - 1;

   logic [31:0] raise;
   logic [31:0] total;

   always_comb begin
      raise = '0;
      if (late_en && (32'(temp_code) > TEMP_REF))
         raise = (32'(temp_code) - TEMP_REF) / TEMP_STEP;
      total = 32'(freq_base) + raise;
      if (total > TOP_STEP)
         total = TOP_STEP;
      next_sel = FW'(total);
   end

endmodule

// File: rtl/tis_countdown.sv
module tis_countdown #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             opp_en,
   input  logic             idle,
   output logic             fire
);

   logic             pend;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_int;
   logic             in_window;

   always_comb begin
      in_window = (cnt - CNT_W'(1)) <= (cur_int >> 1);
      fire      = !pend && ((cnt == CNT_W'(1)) || (opp_en && idle && in_window));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b1;
         cnt     <= '0;
         cur_int <= '0;
      end else if (pend || fire) begin
         pend    <= 1'b0;
         cnt     <= reload_val;
         cur_int <= reload_val;
      end else begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   // R7
   forced_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && cnt == CNT_W'(1)) |=> (cnt == $past(reload_val)));

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !fire) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R3
   wait_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |-> (cnt != '0 && cur_int >= CNT_W'(2)));

endmodule

// File: rtl/test_interval_sched.sv
module test_interval_sched
   import tis_pkg::*;
#(
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned HIST_LEN  = 8,
   parameter int unsigned LIN_BASE  = 100000,
   parameter int unsigned LIN_STEP  = 11250,
   parameter int unsigned EXP_BASE  = 1000000,
   parameter int unsigned NUM_FREQ  = 4,
   parameter int unsigned TEMP_W    = 8,
   parameter int unsigned TEMP_REF  = 40,
   parameter int unsigned TEMP_STEP = 5,
   localparam int unsigned FW = $clog2(NUM_FREQ),
   localparam int unsigned CW = $clog2(HIST_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              policy_sel,
   input  logic              opp_en,
   input  logic              late_en,
   input  logic              idle,
   input  logic              res_valid,
   input  logic              res_fail,
   input  logic [FW-1:0]     freq_base,
   input  logic [TEMP_W-1:0] temp_code,
   output logic              phase_start,
   output logic [FW-1:0]     freq_sel
);

   localparam logic [63:0] CNT_SPAN = 64'(1) << CNT_W;

   if (HIST_LEN < 2) begin : g_bad_hist
      $error("HIST_LEN must be at least 2");
   end
   if (NUM_FREQ < 2) begin : g_bad_freq
      $error("NUM_FREQ must be at least 2");
   end
   if (TEMP_STEP < 1) begin : g_bad_tstep
      $error("TEMP_STEP must be nonzero");
   end
   if (64'(LIN_BASE) >= CNT_SPAN || 64'(EXP_BASE) >= CNT_SPAN) begin : g_bad_span
      $error("longest wait does not fit in CNT_W bits");
   end
   if (64'(LIN_BASE) < 64'(HIST_LEN) * 64'(LIN_STEP) + 64'd2) begin : g_bad_lin
      $error("linear wait at full failure count must stay at least 2");
   end
   if ((EXP_BASE >> HIST_LEN) < 2) begin : g_bad_exp
      $error("halving wait at full failure count must stay at least 2");
   end

   logic [CW-1:0]    fail_cnt;
   logic [CNT_W-1:0] reload_val;
   logic [FW-1:0]    next_sel;
   logic             fire;
   policy_e          pol;

   assign pol = policy_e'(policy_sel);

   tis_fail_window #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_fail  (res_fail),
      .fail_cnt  (fail_cnt)
   );

   tis_interval_calc #(
      .CNT_W    (CNT_W),
      .HIST_LEN (HIST_LEN),
      .LIN_BASE (LIN_BASE),
      .LIN_STEP (LIN_STEP),
      .EXP_BASE (EXP_BASE)
   ) u_calc (
      .pol      (pol),
      .fail_cnt (fail_cnt),
      .interval (reload_val)
   );

   tis_countdown #(.CNT_W(CNT_W)) u_cd (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (reload_val),
      .opp_en     (opp_en),
      .idle       (idle),
      .fire       (fire)
   );

   tis_freq_pick #(
      .NUM_FREQ  (NUM_FREQ),
      .TEMP_W    (TEMP_W),
      .TEMP_REF  (TEMP_REF),
      .TEMP_STEP (TEMP_STEP)
   ) u_freq (
      .late_en   (late_en),
      .freq_base (freq_base),
      .temp_code (temp_code),
      .next_sel  (next_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_start <= 1'b0;
         freq_sel    <= '0;
      end else begin
         phase_start <= fire;
         if (fire) freq_sel <= next_sel;
      end
   end

   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_start |=> !phase_start);

   // R8
   freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(freq_sel) |-> phase_start);

   // R9
   freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_sel <= FW'(NUM_FREQ - 1));

endmodule

// File: tb/test_interval_sched_bench.sv
module test_interval_sched_bench;

   localparam int LB = 800;
   localparam int LS = 90;
   localparam int EB = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       policy_sel = 1'b0;
   logic       opp_en = 1'b0;
   logic       late_en = 1'b0;
   logic       idle = 1'b0;
   logic       res_valid = 1'b0;
   logic       res_fail = 1'b0;
   logic [1:0] freq_base = '0;
   logic [7:0] temp_code = '0;
   logic       phase_start;
   logic [1:0] freq_sel;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   int last_t = 0;
   int g;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   test_interval_sched #(
      .CNT_W(12), .HIST_LEN(8), .LIN_BASE(LB), .LIN_STEP(LS), .EXP_BASE(EB),
      .NUM_FREQ(4), .TEMP_W(8), .TEMP_REF(40), .TEMP_STEP(5)
   ) u_test_interval_sched (
      .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .opp_en(opp_en),
      .late_en(late_en), .idle(idle), .res_valid(res_valid), .res_fail(res_fail),
      .freq_base(freq_base), .temp_code(temp_code),
      .phase_start(phase_start), .freq_sel(freq_sel)
   );

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic pol);
      @(negedge clk);
      rst_n = 1'b0;
      policy_sel = pol;
      repeat (3) @(negedge clk);
      chk("R1 strobe in reset", int'(phase_start), 0);
      chk("R1 freq in reset", int'(freq_sel), 0);
      rst_n = 1'b1;
      last_t = cyc;
   endtask

   task automatic wait_strobe(output int gap);
      do @(negedge clk); while (!phase_start);
      gap = cyc - last_t;
      last_t = cyc;
   endtask

   task automatic feed(input int nf, input int np);
      for (int i = 0; i < nf + np; i++) begin
         @(negedge clk);
         res_valid = 1'b1;
         res_fail = (i < nf);
      end
      @(negedge clk);
      res_valid = 1'b0;
      res_fail = 1'b0;
   endtask

   task automatic gap_after(input logic pol, input int nf, input int np,
                            input int exp, input string req);
      int gg;
      do_reset(pol);
      wait_strobe(gg);
      feed(nf, np);
      wait_strobe(gg);
      wait_strobe(gg);
      chk(req, gg, exp);
   endtask

   task automatic test_reset_first;
      int gg;
      opp_en = 1'b0; late_en = 1'b0; freq_base = '0;
      do_reset(1'b0);
      wait_strobe(gg);
      chk("R1 first linear gap", gg, LB + 1);
      do_reset(1'b1);
      wait_strobe(gg);
      chk("R1 first halving gap", gg, EB + 1);
      wait_strobe(gg);
      chk("R4 halving gap k=0", gg, EB);
   endtask

   task automatic test_linear;
      gap_after(1'b0, 1, 0, LB - LS, "R3 linear k=1");
      gap_after(1'b0, 3, 0, LB - 3 * LS, "R3 linear k=3");
      gap_after(1'b0, 8, 0, LB - 8 * LS, "R3 linear k=8");
      gap_after(1'b0, 8, 3, LB - 5 * LS, "R2 window drops oldest");
      gap_after(1'b0, 0, 8, LB, "R2 passes only");
   endtask

   task automatic test_halving;
      gap_after(1'b1, 2, 0, EB / 4, "R4 halving k=2");
      gap_after(1'b1, 5, 0, EB / 32, "R4 halving k=5");
      gap_after(1'b1, 8, 0, EB / 256, "R4 halving k=8");
   endtask

   task automatic test_policy_switch;
      int gg;
      do_reset(1'b0);
      wait_strobe(gg);
      policy_sel = 1'b1;
      @(negedge clk);
      chk("R5 strobe one cycle", int'(phase_start), 0);
      wait_strobe(gg);
      chk("R5 wait in flight keeps policy", gg, LB);
      wait_strobe(gg);
      chk("R5 new policy at next wait", gg, EB);
      policy_sel = 1'b0;
   endtask

   task automatic opp_gap(input int j1, input int j2, output int gap);
      int t0;
      int d;
      t0 = last_t;
      forever begin
         @(negedge clk);
         d = cyc - t0;
         if (phase_start) break;
         idle = (d == j1 - 1) || (d == j2 - 1);
      end
      idle = 1'b0;
      gap = d;
      last_t = cyc;
   endtask

   task automatic test_opportunistic;
      int gg;
      opp_en = 1'b1;
      do_reset(1'b0);
      wait_strobe(gg);
      chk("R7 forced first gap", gg, LB + 1);
      wait_strobe(gg);
      chk("R7 forced without idle", gg, LB);
      opp_gap(300, 500, gg);
      chk("R6 early idle ignored, window idle starts", gg, 500);
      opp_gap(LB - LB / 2 - 1, LB - LB / 2, gg);
      chk("R6 window edge", gg, LB - LB / 2);
      opp_gap(100, 200, gg);
      chk("R7 only early idles, forced", gg, LB);
      idle = 1'b1;
      wait_strobe(gg);
      chk("R6 idle held high", gg, LB - LB / 2);
      idle = 1'b0;
      opp_en = 1'b0;
   endtask

   task automatic test_freq;
      int gg;
      freq_base = 2'd1; late_en = 1'b0; temp_code = 8'd90;
      do_reset(1'b0);
      wait_strobe(gg);
      chk("R8 base step captured", int'(freq_sel), 1);
      freq_base = 2'd2;
      repeat (20) @(negedge clk);
      chk("R8 step held between strobes", int'(freq_sel), 1);
      wait_strobe(gg);
      chk("R8 new base at strobe", int'(freq_sel), 2);
      late_en = 1'b1; freq_base = 2'd1; temp_code = 8'd44;
      wait_strobe(gg);
      chk("R9 below one step", int'(freq_sel), 1);
      temp_code = 8'd45;
      wait_strobe(gg);
      chk("R9 one step", int'(freq_sel), 2);
      temp_code = 8'd50;
      wait_strobe(gg);
      chk("R9 two steps", int'(freq_sel), 3);
      freq_base = 2'd2; temp_code = 8'd55;
      wait_strobe(gg);
      chk("R9 saturate", int'(freq_sel), 3);
      freq_base = 2'd0; temp_code = 8'd30;
      wait_strobe(gg);
      chk("R9 below reference", int'(freq_sel), 0);
      late_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      g = 0;
      test_reset_first();
      test_linear();
      test_halving();
      test_policy_switch();
      test_opportunistic();
      test_freq();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule